// File: doc/BRIEF.md
# Byte-Packing Data FIFO Engine

This block moves transfer data between a word-wide FIFO on the software side and a byte-wide card data port. On a card-to-FIFO transfer it packs incoming card bytes into FIFO words in little-endian order. On a FIFO-to-card transfer it unpacks FIFO words into bytes and sends the lowest byte first. Software sets a byte length and starts the engine through a control write. It then pushes or pops FIFO words through its own data port and watches a status vector. That vector holds per-direction FIFO flags and end-of-transfer flags.

A byte down-counter tracks the transfer. When the counter reaches zero, the end flags are raised. Once the FIFO has also drained, the engine switches itself off. After software pops a word, card-to-FIFO traffic pauses until software polls the status or the FIFO-count value. This guards against data arriving while software is still reading.

Top module: `byte_pack_fifo_engine`

## Requirements
- R1: The FIFO holds 16 words of 32 bits. A push while it holds 16 words is dropped, and the dropped word never reaches the card.
- R2: In card-to-FIFO mode, the first byte of each word lands in bits [7:0], the next in [15:8], and so on. A final word with fewer than 4 bytes is pushed with its unused upper bytes at zero.
- R3: `card_rx_ready` is high only while all of the following hold: the engine is enabled in card-to-FIFO mode, the byte count is non-zero, the FIFO is not full, and no hold-off is pending. Each accepted byte decrements the count by one.
- R4: In FIFO-to-card mode, each FIFO word is sent as bytes, bits [7:0] first. Each byte accepted by the card decrements the byte count by one.
- R5: A control write with `ctrl_wdata[0]`=1 enables the engine and loads the byte count from the 16-bit length register. `ctrl_wdata[1]` selects the direction: 1 means card-to-FIFO and 0 means FIFO-to-card. A control write with bit 0 at 0 disables the engine.
- R6: While the engine is enabled with a zero byte count, status bit 8 (end) and status bit 10 (block end) become set. They stay set until the next enabling control write. If the FIFO is also empty, the engine disables itself and all FIFO flags read zero.
- R7: While enabled, the FIFO flags are shown only for the current direction. FIFO-to-card uses bit 12 (active), 14 (8 words or fewer), 16 (16 words), 18 (0 words) and 20 (at least 1 word). Card-to-FIFO uses bit 13 (active), 15 (8 words or more), 17 (16 words), 19 (0 words) and 21 (at least 1 word).
- R8: A software pop from a non-empty FIFO blocks further card bytes until a `sw_poll` pulse. Card bytes resume on the cycle after that poll.
- R9: `fifo_words_o` equals the byte count rounded up to whole words, (count+3)/4.
- R10: A software push while the byte count is zero is ignored. A software pop from an empty FIFO returns 0.
- R11: At most one card byte moves per clock cycle, and `card_rx_ready` and `card_tx_valid` are never high together.
- R12: After reset, the engine is disabled, the status is zero, the byte count is zero and `sw_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_we | input | 1 | Write strobe for the length register |
| len_wdata | input | 16 | Transfer length in bytes |
| ctrl_we | input | 1 | Write strobe for control |
| ctrl_wdata | input | 2 | Bit 0 enable, bit 1 direction (1 = card-to-FIFO) |
| sw_push | input | 1 | Software pushes `sw_wdata` into the FIFO |
| sw_wdata | input | 32 | Word pushed by software |
| sw_pop | input | 1 | Software pops the FIFO head |
| sw_rdata | output | 32 | Word from the last pop, valid the cycle after `sw_pop` |
| sw_poll | input | 1 | Status or FIFO-count poll; releases the hold-off |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Engine takes the offered byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card takes the offered byte |
| stat_o | output | 22 | Status flags |
| byte_cnt_o | output | 16 | Remaining byte count |
| fifo_words_o | output | 16 | Remaining count in words |
| xfer_en_o | output | 1 | Engine enabled |
| xfer_dir_o | output | 1 | Current direction |

## Verification
The assertions assume that software never writes the length register and control in the same cycle. They also assume that software pushes words only while a FIFO-to-card transfer is running. The card side is assumed to hold a byte stable only while it is offering it. The stimulus respects all of this: it writes length and control in separate cycles, pushes only after starting a write transfer, and drives all card and software inputs on falling edges. Byte patterns are computed from the byte index, so the expected words, bytes, counts and status values come from arithmetic on the length alone.

// File: rtl/wbx_pkg.sv
package wbx_pkg;
  localparam int STAT_W   = 22;
  localparam int ST_END   = 8;
  localparam int ST_BLK   = 10;
  // Transmit flag positions; each receive flag sits one bit above.
  localparam int ST_ACT   = 12;
  localparam int ST_HALF  = 14;
  localparam int ST_FULL  = 16;
  localparam int ST_EMPTY = 18;
  localparam int ST_AVAIL = 20;
  localparam logic [STAT_W-1:0] TX_MASK = 22'h155000;
  localparam logic [STAT_W-1:0] RX_MASK = 22'h2AA000;
endpackage

// File: rtl/wbx_word_fifo.sv
module wbx_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/wbx_rx_pack.sv
module wbx_rx_pack #(
  parameter int W     = 32,
  localparam int LANES = W / 8,
  localparam int LIW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         take,
  input  logic [7:0]   din,
  input  logic         last,
  output logic         push,
  output logic [W-1:0] word
);
  logic [W-1:0]   acc;
  logic [LIW-1:0] lane;

  assign word = acc | (W'(din) << (lane * 8));
  assign push = take && ((lane == LIW'(LANES - 1)) || last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc  <= '0;
      lane <= '0;
    end else if (take) begin
      if (push) begin
        acc  <= '0;
        lane <= '0;
      end else begin
        acc  <= word;
        lane <= lane + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbx_tx_unpack.sv
module wbx_tx_unpack #(
  parameter int W      = 32,
  localparam int LANES = W / 8,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         take,
  output logic         has,
  output logic [7:0]   dout
);
  logic [W-1:0]  sh;
  logic [CW-1:0] left;

  assign has  = (left != '0);
  assign dout = sh[7:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= word;
      left <= CW'(LANES);
    end else if (take) begin
      sh   <= sh >> 8;
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/byte_pack_fifo_engine.sv
module byte_pack_fifo_engine
  import wbx_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int LB   = $clog2(W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              len_we,
  input  logic [CNT_W-1:0]  len_wdata,
  input  logic              ctrl_we,
  input  logic [1:0]        ctrl_wdata,
  input  logic              sw_push,
  input  logic [W-1:0]      sw_wdata,
  input  logic              sw_pop,
  output logic [W-1:0]      sw_rdata,
  input  logic              sw_poll,
  input  logic              card_rx_valid,
  input  logic [7:0]        card_rx_data,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_data,
  input  logic              card_tx_ready,
  output logic [STAT_W-1:0] stat_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic [CNT_W-1:0]  fifo_words_o,
  output logic              xfer_en_o,
  output logic              xfer_dir_o
);
  localparam int HALF = DEPTH / 2;

  logic [CNT_W-1:0] len_q, cnt;
  logic             en, dir, done, hold;
  logic             cnt_nz, rx_mode, tx_mode;
  logic             rx_fire, tx_fire, rx_push, tx_has, tx_load;
  logic             sw_pop_ok, sw_push_ok;
  logic [W-1:0]     rx_word, fifo_head;
  logic [LW-1:0]    level;
  logic             fifo_full, fifo_empty;
  logic [CNT_W:0]   wsum;

  assign cnt_nz  = (cnt != '0);
  assign rx_mode = en && dir;
  assign tx_mode = en && !dir;

  assign card_rx_ready = rx_mode && cnt_nz && !fifo_full && !hold;
  assign rx_fire       = card_rx_ready && card_rx_valid;
  assign card_tx_valid = tx_mode && cnt_nz && tx_has;
  assign tx_fire       = card_tx_valid && card_tx_ready;
  assign tx_load       = tx_mode && cnt_nz && !tx_has && !fifo_empty && !sw_pop;
  assign sw_pop_ok     = sw_pop && !fifo_empty;
  assign sw_push_ok    = sw_push && cnt_nz && !rx_push;

  wbx_word_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(rx_push || sw_push_ok),
    .push_data(rx_push ? rx_word : sw_wdata),
    .pop(sw_pop || tx_load),
    .pop_data(fifo_head),
    .level(level), .full(fifo_full), .empty(fifo_empty)
  );

  wbx_rx_pack #(.W(W)) u_pack (
    .clk(clk), .rst(rst), .clr(ctrl_we),
    .take(rx_fire), .din(card_rx_data), .last(cnt == CNT_W'(1)),
    .push(rx_push), .word(rx_word)
  );

  wbx_tx_unpack #(.W(W)) u_unpack (
    .clk(clk), .rst(rst), .clr(ctrl_we),
    .load(tx_load), .word(fifo_head), .take(tx_fire),
    .has(tx_has), .dout(card_tx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= '0;
      cnt      <= '0;
      en       <= 1'b0;
      dir      <= 1'b0;
      done     <= 1'b0;
      hold     <= 1'b0;
      sw_rdata <= '0;
    end else begin
      if (len_we) len_q <= len_wdata;
      if (ctrl_we) begin
        en  <= ctrl_wdata[0];
        dir <= ctrl_wdata[1];
        if (ctrl_wdata[0]) begin
          cnt  <= len_q;
          done <= 1'b0;
        end
      end else begin
        if (rx_fire || tx_fire) cnt <= cnt - 1'b1;
        if (en && !cnt_nz) begin
          done <= 1'b1;
          if (fifo_empty) en <= 1'b0;
        end
      end
      if (sw_pop_ok)    hold <= 1'b1;
      else if (sw_poll) hold <= 1'b0;
      if (sw_pop) sw_rdata <= fifo_empty ? '0 : fifo_head;
    end
  end

  // Status: end flags plus FIFO flags of the active direction only.
  always_comb begin
    logic [STAT_W-1:0] f;
    f = '0;
    f[ST_END] = done;
    f[ST_BLK] = done;
    if (en) begin
      f[ST_ACT   + 32'(dir)] = 1'b1;
      f[ST_EMPTY + 32'(dir)] = (level == '0);
      f[ST_AVAIL + 32'(dir)] = (level != '0);
      f[ST_FULL  + 32'(dir)] = (level == LW'(DEPTH));
      f[ST_HALF  + 32'(dir)] = dir ? (level >= LW'(HALF)) : (level <= LW'(HALF));
    end
    stat_o = f;
  end

  assign wsum         = {1'b0, cnt} + (CNT_W + 1)'((W / 8) - 1);
  assign fifo_words_o = CNT_W'(wsum >> LB);
  assign byte_cnt_o   = cnt;
  assign xfer_en_o    = en;
  assign xfer_dir_o   = dir;
endmodule

// File: rtl/wbx_chk.sv
module wbx_chk
  import wbx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_we,
  input logic              sw_pop,
  input logic              fifo_empty,
  input logic              card_rx_ready,
  input logic              card_rx_valid,
  input logic              card_tx_valid,
  input logic              card_tx_ready,
  input logic [STAT_W-1:0] stat_o,
  input logic [CNT_W-1:0]  byte_cnt_o,
  input logic              xfer_en_o
);
  // R11
  one_side_chk: assert property (@(posedge clk) disable iff (rst)
    !(card_rx_ready && card_tx_valid));

  // R3
  rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    card_rx_ready |-> (byte_cnt_o != '0));

  // R8
  holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_pop && !fifo_empty) |=> !card_rx_ready);

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (((card_tx_valid && card_tx_ready) || (card_rx_ready && card_rx_valid)) && !ctrl_we)
      |=> (byte_cnt_o == $past(byte_cnt_o) - 1'b1));

  // R7
  flag_split_chk: assert property (@(posedge clk) disable iff (rst)
    !(((stat_o & TX_MASK) != '0) && ((stat_o & RX_MASK) != '0)));

  // R6
  auto_off_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(xfer_en_o) && !$past(ctrl_we)) |->
      (stat_o[ST_END] && stat_o[ST_BLK] && ((stat_o & (TX_MASK | RX_MASK)) == '0)));
endmodule

bind byte_pack_fifo_engine wbx_chk #(.CNT_W(CNT_W)) u_wbx_chk (
  .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .sw_pop(sw_pop),
  .fifo_empty(fifo_empty), .card_rx_ready(card_rx_ready),
  .card_rx_valid(card_rx_valid), .card_tx_valid(card_tx_valid),
  .card_tx_ready(card_tx_ready), .stat_o(stat_o),
  .byte_cnt_o(byte_cnt_o), .xfer_en_o(xfer_en_o)
);

// File: tb/tb_byte_pack_fifo_engine.sv
`timescale 1ns/1ps
module tb_byte_pack_fifo_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        len_we = 1'b0, ctrl_we = 1'b0, sw_push = 1'b0, sw_pop = 1'b0, sw_poll = 1'b0;
  logic [15:0] len_wdata = '0;
  logic [1:0]  ctrl_wdata = '0;
  logic [31:0] sw_wdata = '0, sw_rdata;
  logic        card_rx_valid = 1'b0, card_rx_ready, card_tx_valid, card_tx_ready = 1'b0;
  logic [7:0]  card_rx_data = '0, card_tx_data;
  logic [21:0] stat_o;
  logic [15:0] byte_cnt_o, fifo_words_o;
  logic        xfer_en_o, xfer_dir_o;

  int checks = 0, fails = 0, cyc = 0, idx = 0, tidx = 0, base = 0;

  always #2.5 clk = ~clk;

  byte_pack_fifo_engine dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29 + base) ^ (i >> 3));
  endfunction

  function automatic logic [31:0] exp_word(int k, int len);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < len) w[8*j +: 8] = pat(4 * k + j);
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic start(int len, bit d);
    len_we = 1'b1; len_wdata = 16'(len); tick(); len_we = 1'b0;
    ctrl_we = 1'b1; ctrl_wdata = {d, 1'b1}; tick(); ctrl_we = 1'b0;
  endtask

  task automatic pop_word(output logic [31:0] w);
    sw_pop = 1'b1; tick(); sw_pop = 1'b0; w = sw_rdata;
  endtask

  task automatic poll();
    sw_poll = 1'b1; tick(); sw_poll = 1'b0;
  endtask

  // Offer bytes pat(idx) until idx reaches target or the budget runs out.
  task automatic feed(int target, bit gap, int budget);
    for (int c = 0; c < budget && idx < target; c++) begin
      card_rx_valid = gap ? (c % 3 != 2) : 1'b1;
      card_rx_data  = pat(idx);
      if (card_rx_valid && card_rx_ready) idx++;
      tick();
    end
    card_rx_valid = 1'b0;
  endtask

  // Accept card bytes and compare each to pat(tidx).
  task automatic drain(int target, bit gap, int budget);
    for (int c = 0; c < budget && tidx < target; c++) begin
      card_tx_ready = gap ? (c % 2 == 0) : 1'b1;
      if (card_tx_valid && card_tx_ready) begin
        chk("R4 tx byte order", 32'(card_tx_data), 32'(pat(tidx)));
        tidx++;
      end
      tick();
    end
    card_tx_ready = 1'b0;
  endtask

  initial begin
    logic [31:0] w;
    tick(); tick(); rst = 1'b0; tick();

    chk("R12 stat", 32'(stat_o), 0);
    chk("R12 cnt", 32'(byte_cnt_o), 0);
    chk("R12 en", 32'(xfer_en_o), 0);
    chk("R12 rdata", sw_rdata, 0);
    chk("R11 idle ports", {30'd0, card_rx_ready, card_tx_valid}, 0);

    // R10: push with zero count is dropped
    sw_push = 1'b1; sw_wdata = 32'hDEADBEEF; tick(); sw_push = 1'b0;
    pop_word(w);
    chk("R10 push at zero count", w, 0);

    // Card-to-FIFO sweep over lengths and pacing
    for (int len = 0; len <= 13; len++) begin
      base = len * 11 + 3; idx = 0;
      start(len, 1'b1);
      chk("R5 count load", 32'(byte_cnt_o), 32'(len));
      chk("R5 direction", 32'(xfer_dir_o), 1);
      chk("R9 words", 32'(fifo_words_o), 32'((len + 3) / 4));
      chk("R7 rx idle flags", 32'(stat_o), 32'((1 << 13) | (1 << 19)));
      feed(len, len[0], 200);
      tick(); tick();
      chk("R6 end flags", 32'(stat_o[10]) << 1 | 32'(stat_o[8]), 3);
      chk("R3 count drained", 32'(byte_cnt_o), 0);
      for (int k = 0; k < (len + 3) / 4; k++) begin
        pop_word(w);
        chk("R2 packed word", w, exp_word(k, len));
        poll();
      end
      tick();
      chk("R6 auto disable", 32'(stat_o), 32'((1 << 8) | (1 << 10)));
      chk("R6 en low", 32'(xfer_en_o), 0);
    end
    pop_word(w);
    chk("R10 pop empty", w, 0);

    // FIFO fill, stall and hold-off in card-to-FIFO mode
    base = 77; idx = 0;
    start(80, 1'b1);
    feed(64, 1'b0, 200);
    tick();
    chk("R3 full stall", 32'(card_rx_ready), 0);
    chk("R7 rx full flags", 32'(stat_o), 32'((1 << 13) | (1 << 15) | (1 << 17) | (1 << 21)));
    chk("R9 words mid", 32'(fifo_words_o), 4);
    pop_word(w);
    chk("R2 first word", w, exp_word(0, 80));
    chk("R7 rx 15 words", 32'(stat_o), 32'((1 << 13) | (1 << 15) | (1 << 21)));
    card_rx_valid = 1'b1; card_rx_data = pat(idx);
    for (int c = 0; c < 3; c++) begin
      chk("R8 held off", 32'(card_rx_ready), 0);
      tick();
    end
    card_rx_valid = 1'b0;
    chk("R8 count frozen", 32'(byte_cnt_o), 16);
    poll();
    chk("R8 released", 32'(card_rx_ready), 1);
    for (int k = 1; k < 20; k++) begin
      feed(80, 1'b0, 8);
      pop_word(w);
      chk("R2 streamed word", w, exp_word(k, 80));
      poll();
    end
    chk("R3 all bytes taken", 32'(idx), 80);
    tick();
    chk("R6 stream end", 32'(stat_o), 32'((1 << 8) | (1 << 10)));

    // FIFO-to-card sweep
    for (int len = 1; len <= 16; len++) begin
      base = len * 5 + 1; tidx = 0;
      start(len, 1'b0);
      chk("R7 tx idle flags", 32'(stat_o), 32'((1 << 12) | (1 << 14) | (1 << 18)));
      for (int k = 0; k < (len + 3) / 4; k++) begin
        sw_push = 1'b1; sw_wdata = exp_word(k, 64); tick();
      end
      sw_push = 1'b0;
      drain(len, len[0], 200);
      chk("R4 byte total", 32'(tidx), 32'(len));
      tick(); tick();
      chk("R6 tx end", 32'(stat_o), 32'((1 << 8) | (1 << 10)));
      chk("R4 count zero", 32'(byte_cnt_o), 0);
    end

    // Overflow: 18 pushes, one in the unpacker, 16 stored, the last dropped
    base = 9; tidx = 0;
    start(100, 1'b0);
    for (int k = 0; k < 18; k++) begin
      sw_push = 1'b1; sw_wdata = (k == 17) ? 32'hA5A5A5A5 : exp_word(k, 100); tick();
    end
    sw_push = 1'b0;
    chk("R7 tx full flags", 32'(stat_o), 32'((1 << 12) | (1 << 16) | (1 << 20)));
    drain(100, 1'b0, 200);
    chk("R1 bytes before stall", 32'(tidx), 68);
    chk("R1 dropped word", 32'(byte_cnt_o), 32);
    chk("R1 no tx after drop", 32'(card_tx_valid), 0);
    chk("R7 tx empty flags", 32'(stat_o), 32'((1 << 12) | (1 << 14) | (1 << 18)));
    chk("R9 words left", 32'(fifo_words_o), 8);
    ctrl_we = 1'b1; ctrl_wdata = 2'b00; tick(); ctrl_we = 1'b0;
    chk("R5 disable", 32'(xfer_en_o), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule